// File: doc/BRIEF.md
# Oscillator-Clocked Reset Sequencer

This block converts a brief pulse on an asynchronous reset pin into a clean, synchronous internal reset. It is clocked from the chip's own oscillator, so it needs no system clock. The oscillator clock may be present but not yet trustworthy. The block raises an oscillator enable for the whole sequence. It waits until a stability indication has stayed high for a set number of cycles. Only then does it time the internal reset window.

The window is timed from the later of two events: the reset pin going low again, or the oscillator being judged stable. The window lasts a parameterised number of oscillator cycles. When it ends, the internal reset is released. One cycle later, the configuration strap pins are captured into holding registers and a ready flag rises. The flag and the captured straps then stay fixed until the next reset pulse.

A new pulse that arrives in the middle of a sequence starts the sequence again. A loss of oscillator stability during the window sends the block back to waiting for the oscillator.

Top module: `osc_reset_seq`

## Requirements
- R1: After the power-on reset `por_n` has been low at a clock edge and then released, with `osc_ok` low: `int_rst_n`=0, `ready`=0, `osc_en`=1 and `cfg_q`=0. A sequence is then pending on the oscillator.
- R2: A high pulse on `ext_rst` lasting at least 2 oscillator cycles starts a sequence. The pin need not be held. Within 3 cycles of the rising edge, `int_rst_n` and `ready` are low.
- R3: While `ready` is low, `osc_en` is high.
- R4: The oscillator counts as started only after `osc_ok` has been high on STABLE_CYCLES (default 2) consecutive clock edges. A single-cycle high on `osc_ok` never releases the internal reset.
- R5: With the oscillator already stable, `int_rst_n` rises exactly RST_CYCLES+4 cycles after `ext_rst` falls. If the pin has already fallen, `int_rst_n` rises exactly RST_CYCLES+3 cycles after `osc_ok` goes high and stays high. RST_CYCLES defaults to 3.
- R6: If `osc_ok` drops during the reset window, the window is abandoned. `int_rst_n` stays low, and release follows RST_CYCLES+3 cycles after `osc_ok` returns.
- R7: A new `ext_rst` pulse during a sequence restarts it from zero. Release then occurs RST_CYCLES+4 cycles after the new pulse ends, and `ready` does not rise in between.
- R8: `cfg_q` keeps its previous value while `int_rst_n` is low. The cycle after `int_rst_n` rises, `cfg_q` takes the value of `cfg_pins` and `ready` rises.
- R9: While `ready` is high and no new pulse occurs, changes on `cfg_pins` are ignored: `cfg_q` and `ready` hold.
- R10: `ready` is never high while `int_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| por_n | input | 1 | Synchronous active-low power-on reset of the sequencer itself |
| ext_rst | input | 1 | Asynchronous reset request pin, active high |
| osc_ok | input | 1 | Oscillator stability indication |
| cfg_pins | input | CFG_W | Configuration strap pins |
| osc_en | output | 1 | Oscillator start request |
| int_rst_n | output | 1 | Internal synchronous reset, active low |
| cfg_q | output | CFG_W | Captured configuration straps |
| ready | output | 1 | Sequence complete and straps captured |

## Verification
The release latency is measured for two cases. In the first, the pin is released while the oscillator is already stable. In the second, the oscillator becomes stable after the pin is released. The two measured counts differ by one cycle, which shows which event opened the window. A one-cycle stability glitch separates true filtering from simple edge sensing. A stability drop during the window and a second pulse during the window both show that the count restarts and is not merely paused. Strap values are changed during the reset and again after ready. This shows that capture happens at one single instant and at no other time.

// File: rtl/rs_pkg.sv
// Package: shared types of the oscillator reset sequencer.
package rs_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_PULSE    = 3'd1,
        SEQ_WAIT_OSC = 3'd2,
        SEQ_COUNT    = 3'd3,
        SEQ_LATCH    = 3'd4
    } seq_state_e;
endpackage

// File: rtl/rs_pin_sync.sv
// rs_pin_sync: brings the asynchronous reset pin into the oscillator domain
// through two flops and reports single-cycle rise and fall strobes.
// Assumes the pin pulse is at least one clock period wide.
module rs_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    // Purpose: two-stage synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // R2: a rise strobe never lasts two cycles
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/rs_osc_filter.sv
// rs_osc_filter: declares the oscillator started once the stability input
// has been high on STABLE_CYCLES consecutive edges; any low clears it.
module rs_osc_filter #(
    parameter int STABLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_ok,
    output logic started
);
    localparam int SW = $clog2(STABLE_CYCLES + 1);
    localparam logic [SW-1:0] FULL = SW'(STABLE_CYCLES);

    logic [SW-1:0] run_q;

    // Purpose: saturating run-length counter of consecutive high samples.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (!osc_ok)      run_q <= '0;
        else if (run_q != FULL) run_q <= run_q + 1'b1;
    end

    assign started = (run_q == FULL);

    // R4: started implies the input was high at the previous edge
    p_started_needs_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> $past(osc_ok));
    // R4: a low sample removes the started state at once
    p_low_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_ok |=> !started);
endmodule

// File: rtl/rs_cfg_latch.sv
// rs_cfg_latch: holding registers for the strap pins, loaded only on capture.
module rs_cfg_latch #(
    parameter int CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CFG_W-1:0] pins,
    output logic [CFG_W-1:0] held
);
    for (genvar b = 0; b < CFG_W; b++) begin : g_bit
        // Purpose: one strap bit, cleared on reset, loaded on capture.
        always_ff @(posedge clk) begin
            if (!rst_n)       held[b] <= 1'b0;
            else if (capture) held[b] <= pins[b];
        end
    end
endmodule

// File: rtl/osc_reset_seq.sv
// osc_reset_seq: turns a short reset pulse into a timed internal reset on the
// oscillator clock, then captures the strap pins and raises ready.
// Assumes clk toggles (possibly unstable) whenever osc_ok may matter.
module osc_reset_seq
    import rs_pkg::*;
#(
    parameter int CFG_W         = 6,
    parameter int RST_CYCLES    = 3,
    parameter int STABLE_CYCLES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst,
    input  logic             osc_ok,
    input  logic [CFG_W-1:0] cfg_pins,
    output logic             osc_en,
    output logic             int_rst_n,
    output logic [CFG_W-1:0] cfg_q,
    output logic             ready
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pin_rise, pin_fall, osc_started;

    rs_pin_sync u_sync (
        .clk(clk), .rst_n(por_n), .pin(ext_rst), .rise(pin_rise), .fall(pin_fall)
    );

    rs_osc_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
        .clk(clk), .rst_n(por_n), .osc_ok(osc_ok), .started(osc_started)
    );

    rs_cfg_latch #(.CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(por_n), .capture(state_q == SEQ_LATCH),
        .pins(cfg_pins), .held(cfg_q)
    );

    // Purpose: next state and window counter; a new pulse always wins.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (pin_rise) begin
            state_d = SEQ_PULSE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                SEQ_PULSE:    if (pin_fall) state_d = SEQ_WAIT_OSC;
                SEQ_WAIT_OSC: if (osc_started) begin
                    state_d = SEQ_COUNT;
                    cnt_d   = '0;
                end
                SEQ_COUNT: begin
                    if (!osc_started)       state_d = SEQ_WAIT_OSC;
                    else if (cnt_q == LAST) state_d = SEQ_LATCH;
                    else                    cnt_d   = cnt_q + 1'b1;
                end
                SEQ_LATCH:    state_d = SEQ_IDLE;
                default:      state_d = SEQ_IDLE;
            endcase
        end
    end

    // Purpose: state, counter and glitch-free registered outputs.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q   <= SEQ_WAIT_OSC;
            cnt_q     <= '0;
            int_rst_n <= 1'b0;
            ready     <= 1'b0;
            osc_en    <= 1'b1;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            int_rst_n <= (state_d == SEQ_LATCH) || (state_d == SEQ_IDLE);
            ready     <= (state_d == SEQ_IDLE);
            osc_en    <= (state_d != SEQ_IDLE);
        end
    end

    // R10: ready only with reset released
    p_ready_released_r10: assert property (@(posedge clk) disable iff (!por_n)
        ready |-> int_rst_n);
    // R3: oscillator requested throughout a sequence
    p_osc_during_seq_r3: assert property (@(posedge clk) disable iff (!por_n)
        !ready |-> osc_en);
    // R8: straps frozen while internal reset is held
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        !int_rst_n |=> $stable(cfg_q));
    // R9: idle without a new pulse keeps ready and straps
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        (ready && !pin_rise) |=> (ready && $stable(cfg_q)));
    // R5: window counter stays in range
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= LAST);
    // R4: the window never runs without a started oscillator
    p_count_needs_osc_r4: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == SEQ_COUNT && cnt_q != '0) |-> $past(osc_started));
endmodule

// File: tb/tb_osc_reset_seq.sv
module tb_osc_reset_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CFG_W = 6;
    localparam int RSTC = 3;
    localparam int STAB = 2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_rst = 1'b0;
    logic osc_ok = 1'b0;
    logic [CFG_W-1:0] cfg_pins = '0;
    logic osc_en, int_rst_n, ready;
    logic [CFG_W-1:0] cfg_q;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_reset_seq #(.CFG_W(CFG_W), .RST_CYCLES(RSTC), .STABLE_CYCLES(STAB)) dut (
        .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .osc_ok(osc_ok),
        .cfg_pins(cfg_pins), .osc_en(osc_en), .int_rst_n(int_rst_n),
        .cfg_q(cfg_q), .ready(ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pulse the pin for w cycles starting at a falling edge; leaves pin high
    task automatic raise_pin(input int w);
        @(negedge clk);
        ext_rst = 1'b1;
        repeat (w) @(negedge clk);
    endtask

    // release pin at this negedge, count negedges until int_rst_n is high
    task automatic release_measure(output int k, output logic early_ready);
        ext_rst = 1'b0;
        k = 0;
        early_ready = 1'b0;
        while (k < 60) begin
            @(negedge clk);
            k++;
            if (int_rst_n) break;
            if (ready) early_ready = 1'b1;
        end
    endtask

    task automatic wait_osc_measure(output int k);
        osc_ok = 1'b1;
        k = 0;
        while (k < 60) begin
            @(negedge clk);
            k++;
            if (int_rst_n) break;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 int_rst_n", int_rst_n, 0);
        check("R1 ready", ready, 0);
        check("R1 osc_en", osc_en, 1);
        check("R1 cfg_q", cfg_q, 0);
    endtask

    task automatic t_boot_osc_late;
        int k;
        cfg_pins = 6'h15;
        repeat (4) @(negedge clk);
        check("R5 waits for oscillator", int_rst_n, 0);
        wait_osc_measure(k);
        check("R5 late oscillator latency", k, RSTC + 3);
        check("R8 straps held at release", cfg_q, 0);
        check("R10 ready at release", ready, 0);
        @(negedge clk);
        check("R8 ready after capture", ready, 1);
        check("R8 straps captured", cfg_q, 6'h15);
    endtask

    task automatic t_pin_stable;
        int k;
        logic er;
        raise_pin(4);
        check("R2 int_rst_n low", int_rst_n, 0);
        check("R2 ready low", ready, 0);
        check("R3 osc_en high", osc_en, 1);
        cfg_pins = 6'h2A;
        release_measure(k, er);
        check("R5 stable oscillator latency", k, RSTC + 4);
        check("R8 old straps at release", cfg_q, 6'h15);
        @(negedge clk);
        check("R8 new straps", cfg_q, 6'h2A);
        check("R8 ready", ready, 1);
    endtask

    task automatic t_ignore_cfg;
        cfg_pins = 6'h07;
        repeat (5) @(negedge clk);
        check("R9 straps ignored", cfg_q, 6'h2A);
        check("R9 ready holds", ready, 1);
    endtask

    task automatic t_osc_glitch;
        int k;
        logic er;
        osc_ok = 1'b0;
        raise_pin(3);
        release_measure(k, er);
        check("R4 no release without oscillator", int_rst_n, 0);
        osc_ok = 1'b1;
        @(negedge clk);
        osc_ok = 1'b0;
        repeat (10) @(negedge clk);
        check("R4 single-cycle glitch ignored", int_rst_n, 0);
        wait_osc_measure(k);
        check("R4 release after stable run", k, RSTC + 3);
        @(negedge clk);
    endtask

    task automatic t_osc_drop;
        int k;
        logic er;
        raise_pin(3);
        ext_rst = 1'b0;
        repeat (4) @(negedge clk);
        osc_ok = 1'b0;
        repeat (8) @(negedge clk);
        check("R6 window abandoned", int_rst_n, 0);
        check("R6 ready low", ready, 0);
        wait_osc_measure(k);
        check("R6 latency after return", k, RSTC + 3);
        @(negedge clk);
    endtask

    task automatic t_restart;
        int k;
        logic er;
        raise_pin(3);
        ext_rst = 1'b0;
        repeat (3) @(negedge clk);
        ext_rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 still in reset", int_rst_n, 0);
        release_measure(k, er);
        check("R7 restart latency", k, RSTC + 4);
        check("R7 no early ready", er, 0);
        @(negedge clk);
        check("R7 ready after restart", ready, 1);
    endtask

    initial begin
        t_reset();
        t_boot_osc_late();
        t_pin_stable();
        t_ignore_cfg();
        t_osc_glitch();
        t_osc_drop();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule